// File: doc/BRIEF.md
# Block-Move DMA Controller

This block copies a run of data words between one peripheral and main memory so that the processor does not have to move each word itself. Software sets up the job through a small register write port: which way the data flows, the peripheral address, the first memory address and how many words to move. A write to the start select then hands the job to the controller, and the processor carries on with other work.

The controller sits on the one shared bus as a separate master. For every word it raises a bus request, waits for the grant, and runs two back-to-back bus cycles. The first cycle reads the word from its source into a one-word holding register. The second cycle writes that word to its destination. After the second cycle it drops the request for at least one clock, so the processor can win the bus between words. When the last word has been written, the controller raises an interrupt. The interrupt stays high until software writes the acknowledge select.

Top module: `blkmove_dma`

## Requirements
- R1: While reset is held and after it is released, `stat_busy`, `stat_done`, `irq`, `bus_req` and `bus_valid` are all 0.
- R2: A write selects a register through `cfg_sel`: 0 is direction (data bit 0; 0 means peripheral to memory, 1 means memory to peripheral), 1 is the peripheral address, 2 is the first memory address, 3 is the word count, 4 is start and 5 is acknowledge. A start with a nonzero count makes `stat_busy` read 1 one clock later.
- R3: `bus_valid` is never high unless `bus_gnt` is high. The controller raises `bus_req` once per word, and `bus_req` is low for at least the clock that follows each word's second cycle.
- R4: With direction 0, each word is a read with `bus_io`=1 at the peripheral address, followed in the next clock by a write with `bus_io`=0 to memory. The write carries exactly the data that the read returned.
- R5: With direction 1, each word is a memory read (`bus_io`=0) followed by a peripheral write (`bus_io`=1). Words reach the peripheral in increasing memory-address order.
- R6: The memory address starts at the programmed value and goes up by one after each word. Every peripheral cycle uses the programmed peripheral address.
- R7: After exactly the programmed number of words, `stat_busy` falls and `stat_done` and `irq` rise, and they are never high together with `stat_busy`.
- R8: A write to the acknowledge select clears `stat_done` and `irq` on the next clock. A start also clears them.
- R9: A start with a count of 0 sets `stat_done` and `irq` on the next clock, never raises `bus_req`, and leaves `stat_busy` at 0.
- R10: While `stat_busy` is 1, every register write is ignored, start included. The running job finishes with its original settings.
- R11: While `bus_gnt` stays low, the controller holds `bus_req` high and runs no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | ADDR_W | Register write data; the count uses the low CNT_W bits |
| stat_busy | output | 1 | A job is in progress |
| stat_done | output | 1 | The job has finished and is not yet acknowledged |
| irq | output | 1 | Completion interrupt |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_valid | output | 1 | A bus cycle is active this clock |
| bus_wr | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_io | output | 1 | 1 = peripheral cycle, 0 = memory cycle |
| bus_addr | output | ADDR_W | Cycle address |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, sampled at the end of a read cycle |

## Verification
The failure modes to watch for are the following.

- **Holding register:** if it loads at the wrong moment, the wrong data appears on the very next write cycle, one clock after the read.
- **Address counter:** if it advances wrongly, memory contents end up shifted or overwritten, which shows after the first word.
- **Count counter:** if it is off by one, the job stops one word early or late, so `irq` rises at the wrong time and the count of request pulses is wrong.
- **Sequencer:** if it skips the gap state, `bus_req` stays high across words, which the per-word request count shows.

A configuration lock that leaks only shows up after the job completes, as data at an unexpected address.

// File: rtl/blkmove_pkg.sv
package blkmove_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_REQ,
    SQ_FIRST,
    SQ_SECOND,
    SQ_GAP
  } seq_state_t;

  localparam logic [2:0] SEL_DIR = 3'd0;
  localparam logic [2:0] SEL_DEV = 3'd1;
  localparam logic [2:0] SEL_MEM = 3'd2;
  localparam logic [2:0] SEL_CNT = 3'd3;
  localparam logic [2:0] SEL_GO  = 3'd4;
  localparam logic [2:0] SEL_ACK = 3'd5;

endpackage

// File: rtl/blkmove_cfg.sv
module blkmove_cfg
  import blkmove_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        sel,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              step,
  output logic              dir_out,
  output logic [ADDR_W-1:0] dev_addr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              cnt_zero,
  output logic              cnt_last
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic              dir_q, dir_d;
  logic [ADDR_W-1:0] dev_q, dev_d, mem_q, mem_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    dir_d = dir_q;
    dev_d = dev_q;
    mem_d = mem_q;
    cnt_d = cnt_q;
    if (wr_en) begin
      case (sel)
        SEL_DIR: dir_d = wdata[0];
        SEL_DEV: dev_d = wdata;
        SEL_MEM: mem_d = wdata;
        SEL_CNT: cnt_d = wdata[CNT_W-1:0];
        default: ;
      endcase
    end else if (step) begin
      mem_d = mem_q + 1'b1;
      cnt_d = cnt_q - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
      dev_q <= '0;
      mem_q <= '0;
      cnt_q <= '0;
    end else begin
      dir_q <= dir_d;
      dev_q <= dev_d;
      mem_q <= mem_d;
      cnt_q <= cnt_d;
    end
  end

  assign dir_out  = dir_q;
  assign dev_addr = dev_q;
  assign mem_addr = mem_q;
  assign cnt_zero = (cnt_q == '0);
  assign cnt_last = (cnt_q == CNT_ONE);

endmodule

// File: rtl/blkmove_seq.sv
module blkmove_seq
  import blkmove_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic ack,
  input  logic gnt,
  input  logic cnt_zero,
  input  logic cnt_last,
  output logic busy,
  output logic done,
  output logic req,
  output logic first_cyc,
  output logic second_cyc
);

  seq_state_t st_q, st_d;
  logic       done_q, done_d;

  always_comb begin
    st_d   = st_q;
    done_d = done_q;
    if (ack || go) done_d = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (go) begin
          if (cnt_zero) done_d = 1'b1;
          else          st_d   = SQ_REQ;
        end
      end
      SQ_REQ:    if (gnt) st_d = SQ_FIRST;
      SQ_FIRST:  st_d = SQ_SECOND;
      SQ_SECOND: begin
        if (cnt_last) begin
          st_d   = SQ_IDLE;
          done_d = 1'b1;
        end else begin
          st_d = SQ_GAP;
        end
      end
      SQ_GAP:  st_d = SQ_REQ;
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  assign busy       = (st_q != SQ_IDLE);
  assign done       = done_q;
  assign req        = (st_q == SQ_REQ) || (st_q == SQ_FIRST) || (st_q == SQ_SECOND);
  assign first_cyc  = (st_q == SQ_FIRST);
  assign second_cyc = (st_q == SQ_SECOND);

endmodule

// File: rtl/blkmove_port.sv
module blkmove_port #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              first_cyc,
  input  logic              second_cyc,
  input  logic              dir_out,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] rdata,
  output logic              valid,
  output logic              wr,
  output logic              io,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata
);

  logic [DATA_W-1:0] hold_q, hold_d;

  always_comb begin
    hold_d = hold_q;
    if (first_cyc) hold_d = rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assign valid = first_cyc | second_cyc;
  assign wr    = second_cyc;
  // The source side comes first; direction 0 reads the peripheral first.
  assign io    = first_cyc ? ~dir_out : (second_cyc ? dir_out : 1'b0);
  assign addr  = io ? dev_addr : mem_addr;
  assign wdata = hold_q;

endmodule

// File: rtl/blkmove_dma.sv
module blkmove_dma
  import blkmove_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              stat_busy,
  output logic              stat_done,
  output logic              irq,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_valid,
  output logic              bus_wr,
  output logic              bus_io,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              busy, done, wr_en, go, ack, step, first_cyc;
  logic              dir_q, cnt_zero, cnt_last;
  logic [ADDR_W-1:0] dev_addr, mem_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign wr_en = cfg_we & ~busy;
  assign go    = wr_en & (cfg_sel == SEL_GO);
  assign ack   = wr_en & (cfg_sel == SEL_ACK);

  blkmove_cfg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (wr_en),
    .sel      (cfg_sel),
    .wdata    (cfg_wdata),
    .step     (step),
    .dir_out  (dir_q),
    .dev_addr (dev_addr),
    .mem_addr (mem_addr),
    .cnt_zero (cnt_zero),
    .cnt_last (cnt_last)
  );

  blkmove_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .go         (go),
    .ack        (ack),
    .gnt        (bus_gnt),
    .cnt_zero   (cnt_zero),
    .cnt_last   (cnt_last),
    .busy       (busy),
    .done       (done),
    .req        (bus_req),
    .first_cyc  (first_cyc),
    .second_cyc (step)
  );

  blkmove_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .first_cyc  (first_cyc),
    .second_cyc (step),
    .dir_out    (dir_q),
    .dev_addr   (dev_addr),
    .mem_addr   (mem_addr),
    .rdata      (bus_rdata),
    .valid      (bus_valid),
    .wr         (bus_wr),
    .io         (bus_io),
    .addr       (bus_addr),
    .wdata      (bus_wdata)
  );

  assign stat_busy = busy;
  assign stat_done = done;
  assign irq       = done;

endmodule

// File: rtl/blkmove_dma_chk.sv
module blkmove_dma_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [2:0]        cfg_sel,
  input logic              stat_busy,
  input logic              stat_done,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              bus_valid,
  input logic              bus_wr,
  input logic              bus_io,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata
);

  // R3
  cycle_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> bus_gnt);

  // R3
  req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_wr) |=> !bus_req);

  // R4
  read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_wr) |=> (bus_valid && bus_wr && (bus_io != $past(bus_io))));

  // R4
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_wr) |=> (bus_wdata == $past(bus_rdata)));

  // R7
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_done && stat_busy));

  // R8
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_sel == 3'd5) && !stat_busy) |=> !stat_done);

endmodule

bind blkmove_dma blkmove_dma_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_sel   (cfg_sel),
  .stat_busy (stat_busy),
  .stat_done (stat_done),
  .bus_req   (bus_req),
  .bus_gnt   (bus_gnt),
  .bus_valid (bus_valid),
  .bus_wr    (bus_wr),
  .bus_io    (bus_io),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata)
);

// File: tb/blkmove_dma_test.sv
`timescale 1ns/1ps
module blkmove_dma_test;

  localparam int AW = 16;
  localparam int DW = 16;
  localparam logic [AW-1:0] DEV = 16'h0F03;

  logic          clk, rst_n, cfg_we, gnt_en;
  logic [2:0]    cfg_sel;
  logic [AW-1:0] cfg_wdata;
  logic          stat_busy, stat_done, irq, bus_req, bus_gnt, bus_valid, bus_wr, bus_io;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;

  int tests_run = 0;
  int tests_failed = 0;

  // Bus-side models.
  logic [DW-1:0] mem_q [0:63];
  logic          mem_w [0:63];
  logic [DW-1:0] sink_q [0:31];
  int src_ptr = 0;
  int sink_ptr = 0;
  int req_rises = 0;
  int valid_cnt = 0;
  int bad_dev = 0;
  int no_gnt = 0;
  logic req_prev = 1'b0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  assign bus_gnt = bus_req & gnt_en;

  function automatic logic [DW-1:0] src_val(int i);
    return DW'(16'hA000 + i);
  endfunction

  function automatic logic [DW-1:0] mem_dflt(int a);
    return DW'(16'h5000 + a);
  endfunction

  always_comb begin
    if (bus_io) bus_rdata = src_val(src_ptr);
    else        bus_rdata = mem_w[bus_addr[5:0]] ? mem_q[bus_addr[5:0]] : mem_dflt(int'(bus_addr[5:0]));
  end

  initial begin
    for (int i = 0; i < 64; i++) mem_w[i] = 1'b0;
  end

  always @(posedge clk) begin
    req_prev <= bus_req;
    if (bus_req && !req_prev) req_rises <= req_rises + 1;
    if (bus_valid) begin
      valid_cnt <= valid_cnt + 1;
      if (!bus_gnt) no_gnt <= no_gnt + 1;
      if (bus_io && bus_addr != DEV) bad_dev <= bad_dev + 1;
      if (bus_wr && bus_io) begin
        sink_q[sink_ptr % 32] <= bus_wdata;
        sink_ptr <= sink_ptr + 1;
      end else if (bus_wr) begin
        mem_q[bus_addr[5:0]] <= bus_wdata;
        mem_w[bus_addr[5:0]] <= 1'b1;
      end else if (bus_io) begin
        src_ptr <= src_ptr + 1;
      end
    end
  end

  blkmove_dma uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .stat_busy(stat_busy), .stat_done(stat_done), .irq(irq),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_valid(bus_valid), .bus_wr(bus_wr),
    .bus_io(bus_io), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [2:0] sel, logic [AW-1:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(logic dir, logic [AW-1:0] maddr, int n);
    wr_reg(3'd0, AW'(dir));
    wr_reg(3'd1, DEV);
    wr_reg(3'd2, maddr);
    wr_reg(3'd3, AW'(n));
  endtask

  task automatic wait_done();
    for (int i = 0; i < 400 && !stat_done; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 busy", 32'(stat_busy), 0);
    check("R1 done", 32'(stat_done), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 req", 32'(bus_req), 0);
    check("R1 valid", 32'(bus_valid), 0);
  endtask

  task automatic t_input();
    int s0 = src_ptr;
    int r0 = req_rises;
    setup(1'b0, 16'd8, 4);
    wr_reg(3'd4, '0);
    check("R2 busy after start", 32'(stat_busy), 1);
    wait_done();
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      check("R4 mem data", 32'(mem_q[8 + k]), 32'(src_val(s0 + k)));
      check("R6 mem written", 32'(mem_w[8 + k]), 1);
    end
    check("R6 no overrun", 32'(mem_w[12]), 0);
    check("R3 one request per word", 32'(req_rises - r0), 4);
    check("R7 done", 32'(stat_done), 1);
    check("R7 irq", 32'(irq), 1);
    check("R7 not busy", 32'(stat_busy), 0);
    check("R6 device addr", 32'(bad_dev), 0);
  endtask

  task automatic t_ack();
    wr_reg(3'd5, '0);
    check("R8 done cleared", 32'(stat_done), 0);
    check("R8 irq cleared", 32'(irq), 0);
  endtask

  task automatic t_output();
    int k0 = sink_ptr;
    setup(1'b1, 16'd20, 3);
    wr_reg(3'd4, '0);
    wait_done();
    @(negedge clk);
    check("R5 words out", 32'(sink_ptr - k0), 3);
    for (int k = 0; k < 3; k++)
      check("R5 sink order", 32'(sink_q[(k0 + k) % 32]), 32'(mem_dflt(20 + k)));
    check("R5 memory untouched", 32'(mem_w[20]), 0);
    check("R7 irq", 32'(irq), 1);
  endtask

  task automatic t_zero();
    int r0 = req_rises;
    int v0 = valid_cnt;
    setup(1'b0, 16'd50, 0);
    wr_reg(3'd4, '0);
    check("R9 done next clock", 32'(stat_done), 1);
    check("R9 irq", 32'(irq), 1);
    check("R9 not busy", 32'(stat_busy), 0);
    repeat (5) @(negedge clk);
    check("R9 no request", 32'(req_rises - r0), 0);
    check("R9 no cycles", 32'(valid_cnt - v0), 0);
  endtask

  task automatic t_locked();
    int s0 = src_ptr;
    int v0 = valid_cnt;
    gnt_en = 1'b0;
    setup(1'b0, 16'd30, 3);
    wr_reg(3'd4, '0);
    repeat (10) @(negedge clk);
    check("R11 request held", 32'(bus_req), 1);
    check("R11 no cycles", 32'(valid_cnt - v0), 0);
    wr_reg(3'd2, 16'd40);
    wr_reg(3'd3, 16'd1);
    wr_reg(3'd0, 16'd1);
    wr_reg(3'd4, '0);
    gnt_en = 1'b1;
    wait_done();
    @(negedge clk);
    for (int k = 0; k < 3; k++)
      check("R10 original job", 32'(mem_q[30 + k]), 32'(src_val(s0 + k)));
    check("R10 ignored addr", 32'(mem_w[40]), 0);
    check("R3 no cycle without grant", 32'(no_gnt), 0);
  endtask

  task automatic t_single();
    int s0 = src_ptr;
    setup(1'b0, 16'd60, 1);
    wr_reg(3'd4, '0);
    check("R8 start clears done", 32'(stat_done), 0);
    wait_done();
    @(negedge clk);
    check("R7 single word", 32'(mem_q[60]), 32'(src_val(s0)));
    check("R7 no second word", 32'(mem_w[61]), 0);
  endtask

  initial begin
    #1000000;
    $display("[TB] %0d tests run, %0d failed", tests_run + 1, tests_failed + 1);
    $display("FAIL watchdog: actual timeout expected finish");
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0; gnt_en = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_input();
    t_ack();
    t_output();
    t_zero();
    t_locked();
    t_single();
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule